// File: doc/BRIEF.md
# Receive Task Sequencer with Overlapped Host Access

This block sits between a modem receive path and a host processor and works in tasks. Received 2-bit symbols are stored without pause in a symbol FIFO. The host writes a task code to the command register. The block then waits until the FIFO holds as many symbols as that task needs. It packs those symbols into bytes, four symbols to a byte, and puts the bytes in a small data buffer. When the buffer is filled, it reports completion through a status flag and an optional active-low interrupt pin.

Symbols keep arriving while the host reads the finished task's bytes and queues the next task. Symbol capture therefore overlaps with host access, and the next task usually finds its symbols already waiting. Demodulation and error correction are not part of this block. Plain symbol packing takes their place.

The host bus is byte-wide and has four addresses:

| Address | Register | Access |
|---------|----------|--------|
| 0 | command | write |
| 1 | status | read |
| 2 | mode | read/write |
| 3 | data | read |

Status bit positions:

| Bit | Meaning |
|-----|---------|
| 0 | buffer free |
| 1 | completion flag |
| 2 | sticky command error |
| 3 | sticky overflow |

Mode bit 0 enables the interrupt.

Top module: `rx_task_seq`

## Requirements
- R1: After reset, the status register reads 0x01 (free set, all other bits clear) and irqN is high.
- R2: A write to the command register while status bit 0 reads 1 is accepted, and bit 0 reads 0 from the next cycle on.
- R3: An accepted task stays pending, with bit 0 at 0, until the symbol FIFO holds at least that task's symbol count. Only then are its symbols consumed.
- R4: On completion, status bit 0 and status bit 1 become 1 in the same cycle. The data buffer already holds the task's bytes by then.
- R5: irqN is low exactly when status bit 1 is set and mode bit 0 is 1. When mode bit 0 is 0, irqN stays high.
- R6: Four symbols form each byte, and the first-received symbol goes in bits 7:6. Successive reads of the data register return byte 0 first, then bytes 1, 2 and so on.
- R7: Command bits 1:0 select the task size: 0 is 4 symbols (1 byte), 1 is 8 symbols (2 bytes), 2 is 16 symbols (4 bytes) and 3 is 32 symbols (8 bytes).
- R8: A command write while bit 0 reads 0 is ignored: the pending task and its size are unchanged. It also sets status bit 2, which stays set until reset.
- R9: A read of the status register clears status bit 1, and irqN returns high.
- R10: A symbol that arrives while the FIFO holds SYM_DEPTH symbols is dropped and leaves the stored symbols unchanged. It sets status bit 3, which stays set until reset.
- R11: Completion of a task resets the data read position to byte 0, however many bytes of the earlier task were read.
- R12: Symbols received before a task is written, including those that arrive while the host reads earlier data, are kept in order and used by that task.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busWr | input | 1 | Register write strobe |
| busRd | input | 1 | Register read strobe (side effects at the clock edge) |
| busAddr | input | 2 | Register address |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, combinational from busAddr |
| symValid | input | 1 | Symbol strobe |
| symData | input | 2 | Received symbol |
| irqN | output | 1 | Active-low interrupt |

## Verification
The assertions assume that busWr and busRd are never high in the same cycle and that both are clean single-cycle strobes. They also assume the address is stable while a strobe is high. The bench drives every bus access through one task that raises exactly one strobe for one cycle, with the address already set. It changes symbols and strobes only at the falling clock edge. The bench never asks for more symbols than the FIFO can hold. It fills the FIFO to its limit only on purpose, in the overflow scenario.

// File: rtl/rx_task_pkg.sv
package rx_task_pkg;
  localparam int SYM_W   = 2;
  localparam int BYTE_W  = 8;
  localparam int SYM_PER_BYTE = BYTE_W / SYM_W;
  localparam int CODE_W  = 2;

  localparam logic [1:0] ADDR_CMD  = 2'd0;
  localparam logic [1:0] ADDR_STS  = 2'd1;
  localparam logic [1:0] ADDR_MODE = 2'd2;
  localparam logic [1:0] ADDR_DATA = 2'd3;

  typedef struct packed {
    logic start;  // task accepted: clear packing state
    logic pop;    // consume one symbol
    logic done;   // last symbol of task consumed this cycle
  } ctl_strb_t;
endpackage

// File: rtl/rx_task_dp.sv
module rx_task_dp
  import rx_task_pkg::*;
#(
  parameter int SYM_DEPTH  = 64,
  parameter int DBUF_BYTES = 8
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             symValid,
  input  logic [SYM_W-1:0]                 symData,
  input  ctl_strb_t                        strb,
  input  logic                             dataRd,
  output logic [$clog2(SYM_DEPTH+1)-1:0]   fifoCount,
  output logic                             symDrop,
  output logic [BYTE_W-1:0]                rdByte
);
  localparam int PTR_W = $clog2(SYM_DEPTH);
  localparam int CNT_W = $clog2(SYM_DEPTH+1);
  localparam int BI_W  = $clog2(DBUF_BYTES);
  localparam int SI_W  = $clog2(SYM_PER_BYTE);

  logic [SYM_W-1:0]  symMem [SYM_DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic              fifoFull, doPush;
  logic [SYM_W-1:0]  popSym;

  logic [BYTE_W-1:0] dataBuf [DBUF_BYTES];
  logic [BYTE_W-1:0] shReg;
  logic [SI_W-1:0]   symIdx;
  logic [BI_W-1:0]   byteIdx, hostPtr;

  assign fifoFull = (fifoCount == CNT_W'(SYM_DEPTH));
  assign doPush   = symValid && !fifoFull;
  assign symDrop  = symValid && fifoFull;
  assign popSym   = symMem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) symMem[wrPtr] <= symData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      fifoCount <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == PTR_W'(SYM_DEPTH-1)) ? '0 : wrPtr + 1'b1;
      if (strb.pop) rdPtr <= (rdPtr == PTR_W'(SYM_DEPTH-1)) ? '0 : rdPtr + 1'b1;
      case ({doPush, strb.pop})
        2'b10:   fifoCount <= fifoCount + 1'b1;
        2'b01:   fifoCount <= fifoCount - 1'b1;
        default: fifoCount <= fifoCount;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg   <= '0;
      symIdx  <= '0;
      byteIdx <= '0;
      hostPtr <= '0;
      for (int i = 0; i < DBUF_BYTES; i++) dataBuf[i] <= '0;
    end else begin
      if (strb.start) begin
        symIdx  <= '0;
        byteIdx <= '0;
      end else if (strb.pop) begin
        shReg  <= {shReg[BYTE_W-SYM_W-1:0], popSym};
        symIdx <= symIdx + 1'b1;
        if (symIdx == SI_W'(SYM_PER_BYTE-1)) begin
          dataBuf[byteIdx] <= {shReg[BYTE_W-SYM_W-1:0], popSym};
          byteIdx <= byteIdx + 1'b1;
        end
      end
      if (strb.done)  hostPtr <= '0;
      else if (dataRd) hostPtr <= hostPtr + 1'b1;
    end
  end

  assign rdByte = dataBuf[hostPtr];
endmodule

// File: rtl/rx_task_ctl.sv
module rx_task_ctl
  import rx_task_pkg::*;
#(
  parameter int SYM_DEPTH = 64
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           cmdWr,
  input  logic                           modeWr,
  input  logic                           stsRd,
  input  logic [BYTE_W-1:0]              busWdata,
  input  logic [$clog2(SYM_DEPTH+1)-1:0] fifoCount,
  input  logic                           symDrop,
  output ctl_strb_t                      strb,
  output logic                           bufFree,
  output logic                           irqFlag,
  output logic                           cmdErr,
  output logic                           ovfFlag,
  output logic                           irqEn
);
  localparam int CNT_W = $clog2(SYM_DEPTH+1);

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_PACK} st_t;
  st_t              state;
  logic [CNT_W-1:0] need, popCnt;
  logic             accept, lastPop;

  assign bufFree = (state == ST_IDLE);
  assign accept  = cmdWr && bufFree;
  assign lastPop = (state == ST_PACK) && (popCnt == need - 1'b1);

  always_comb begin
    strb       = '0;
    strb.start = accept;
    strb.pop   = (state == ST_PACK);
    strb.done  = lastPop;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      need   <= '0;
      popCnt <= '0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          need  <= CNT_W'(SYM_PER_BYTE) << busWdata[CODE_W-1:0];
          state <= ST_WAIT;
        end
        ST_WAIT: if (fifoCount >= need) begin
          popCnt <= '0;
          state  <= ST_PACK;
        end
        ST_PACK: begin
          popCnt <= popCnt + 1'b1;
          if (lastPop) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqFlag <= 1'b0;
      cmdErr  <= 1'b0;
      ovfFlag <= 1'b0;
      irqEn   <= 1'b0;
    end else begin
      if (lastPop)    irqFlag <= 1'b1;
      else if (stsRd) irqFlag <= 1'b0;
      if (cmdWr && !bufFree) cmdErr <= 1'b1;
      if (symDrop) ovfFlag <= 1'b1;
      if (modeWr)  irqEn <= busWdata[0];
    end
  end
endmodule

// File: rtl/rx_task_seq.sv
module rx_task_seq
  import rx_task_pkg::*;
#(
  parameter int SYM_DEPTH  = 64,
  parameter int DBUF_BYTES = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busWr,
  input  logic        busRd,
  input  logic [1:0]  busAddr,
  input  logic [7:0]  busWdata,
  output logic [7:0]  busRdata,
  input  logic        symValid,
  input  logic [1:0]  symData,
  output logic        irqN
);
  localparam int CNT_W = $clog2(SYM_DEPTH+1);

  ctl_strb_t         strb;
  logic [CNT_W-1:0]  fifoCount;
  logic              symDrop, stsFree, stsIrq, stsErr, stsOvf, modeIrqEn;
  logic [BYTE_W-1:0] rdByte;

  rx_task_ctl #(.SYM_DEPTH(SYM_DEPTH)) u_ctl (
    .clk(clk), .rstN(rstN),
    .cmdWr(busWr && busAddr == ADDR_CMD),
    .modeWr(busWr && busAddr == ADDR_MODE),
    .stsRd(busRd && busAddr == ADDR_STS),
    .busWdata(busWdata), .fifoCount(fifoCount), .symDrop(symDrop),
    .strb(strb), .bufFree(stsFree), .irqFlag(stsIrq), .cmdErr(stsErr),
    .ovfFlag(stsOvf), .irqEn(modeIrqEn)
  );

  rx_task_dp #(.SYM_DEPTH(SYM_DEPTH), .DBUF_BYTES(DBUF_BYTES)) u_dp (
    .clk(clk), .rstN(rstN), .symValid(symValid), .symData(symData),
    .strb(strb), .dataRd(busRd && busAddr == ADDR_DATA),
    .fifoCount(fifoCount), .symDrop(symDrop), .rdByte(rdByte)
  );

  always_comb begin
    case (busAddr)
      ADDR_STS:  busRdata = {4'b0, stsOvf, stsErr, stsIrq, stsFree};
      ADDR_MODE: busRdata = {7'b0, modeIrqEn};
      ADDR_DATA: busRdata = rdByte;
      default:   busRdata = '0;
    endcase
  end

  assign irqN = !(stsIrq && modeIrqEn);
endmodule

// File: rtl/rx_task_seq_chk.sv
module rx_task_seq_chk
  import rx_task_pkg::*;
#(
  parameter int SYM_DEPTH = 64
) (
  input logic                           clk,
  input logic                           rstN,
  input logic                           busWr,
  input logic                           busRd,
  input logic [1:0]                     busAddr,
  input logic                           bufFree,
  input logic                           irqFlag,
  input logic                           cmdErr,
  input logic                           irqEn,
  input logic                           irqN,
  input logic                           pop,
  input logic                           done,
  input logic [$clog2(SYM_DEPTH+1)-1:0] fifoCount
);
  assert_cmd_accept_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == ADDR_CMD && bufFree) |=> !bufFree);

  assert_pop_has_data_R3: assert property (@(posedge clk) disable iff (!rstN)
    pop |-> (fifoCount != 0));

  assert_free_with_irq_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(bufFree) |-> irqFlag);

  assert_pin_gated_R5: assert property (@(posedge clk) disable iff (!rstN)
    !irqEn |-> irqN);

  assert_busy_cmd_ignored_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == ADDR_CMD && !bufFree && !done) |=> (!bufFree && cmdErr));

  assert_sts_read_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && busAddr == ADDR_STS && !done) |=> (!irqFlag && irqN));

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rstN)
    fifoCount <= ($clog2(SYM_DEPTH+1))'(SYM_DEPTH));
endmodule

bind rx_task_seq rx_task_seq_chk #(.SYM_DEPTH(SYM_DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
  .bufFree(stsFree), .irqFlag(stsIrq), .cmdErr(stsErr), .irqEn(modeIrqEn),
  .irqN(irqN), .pop(strb.pop), .done(strb.done), .fifoCount(fifoCount)
);

// File: tb/tb_rx_task_seq.sv
`timescale 1ns/1ps
module tb_rx_task_seq;
  logic       clk = 0;
  logic       rstN = 0;
  logic       busWr = 0, busRd = 0, symValid = 0;
  logic [1:0] busAddr = 0, symData = 0;
  logic [7:0] busWdata = 0, busRdata;
  logic       irqN;
  int total = 0, bad = 0;

  rx_task_seq dut (.*);

  always #4 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); busAddr = a; busWdata = d; busWr = 1;
    @(posedge clk); #1 busWr = 0;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); busAddr = a; busRd = 1; #1 d = busRdata;
    @(posedge clk); #1 busRd = 0;
  endtask

  task automatic sendSym(input logic [1:0] s);
    @(negedge clk); symData = s; symValid = 1;
    @(posedge clk); #1 symValid = 0;
  endtask

  task automatic sendByte(input logic [7:0] b);
    for (int i = 3; i >= 0; i--) sendSym(b[2*i +: 2]);
  endtask

  task automatic waitFree(output logic [7:0] sts);
    sts = 0;
    for (int i = 0; i < 400; i++) begin
      busRead(2'd1, sts);
      if (sts[0]) break;
    end
  endtask

  task automatic testReset();
    logic [7:0] v;
    busRead(2'd1, v);
    check("R1 status after reset", v, 8'h01);
    check("R1 irqN after reset", irqN, 1);
  endtask

  task automatic testBasic();
    logic [7:0] v;
    sendByte(8'hC6);
    busWrite(2'd0, 8'h00);
    busRead(2'd1, v);
    check("R2 free cleared after accept", v[0], 0);
    repeat (30) @(negedge clk);
    check("R5 irqN high when disabled", irqN, 1);
    busRead(2'd1, v);
    check("R4 free and irq together", v, 8'h03);
    busRead(2'd3, v);
    check("R6 R7 packed byte code0", v, 8'hC6);
  endtask

  task automatic testWait();
    logic [7:0] v;
    busWrite(2'd2, 8'h01);
    busWrite(2'd0, 8'h01);
    sendByte(8'h5A);
    sendSym(2'b11);
    repeat (20) @(negedge clk);
    busRead(2'd1, v);
    check("R3 still pending with 5 of 8 symbols", v[0], 0);
    check("R3 irqN high while pending", irqN, 1);
    sendSym(2'b10); sendSym(2'b00); sendSym(2'b01);
    for (int i = 0; i < 100 && irqN; i++) @(negedge clk);
    check("R5 irqN low on completion", irqN, 0);
    busRead(2'd1, v);
    check("R4 status on completion", v, 8'h03);
    @(negedge clk);
    check("R9 irqN released after status read", irqN, 1);
    busRead(2'd1, v);
    check("R9 irq bit cleared", v[1], 0);
    busRead(2'd3, v);
    check("R6 byte0 first", v, 8'h5A);
    busRead(2'd3, v);
    check("R6 R7 byte1 second", v, 8'hE1);
  endtask

  task automatic testBusy();
    logic [7:0] v;
    busWrite(2'd0, 8'h00);
    busWrite(2'd0, 8'h03);
    busRead(2'd1, v);
    check("R8 error set, still busy", v & 8'h05, 8'h04);
    sendByte(8'h3C);
    waitFree(v);
    check("R8 done after 4 symbols", v[0], 1);
    busRead(2'd3, v);
    check("R8 data of original task", v, 8'h3C);
    busRead(2'd1, v);
    check("R8 error sticky", v[2], 1);
  endtask

  task automatic testPtrReset();
    logic [7:0] v;
    busWrite(2'd0, 8'h02);
    sendByte(8'h12); sendByte(8'h34); sendByte(8'h56); sendByte(8'h78);
    waitFree(v);
    busRead(2'd3, v); check("R7 code2 byte0", v, 8'h12);
    busRead(2'd3, v); check("R7 code2 byte1", v, 8'h34);
    busWrite(2'd0, 8'h00);
    sendByte(8'h9A);
    waitFree(v);
    busRead(2'd3, v); check("R11 pointer back to byte0", v, 8'h9A);
  endtask

  task automatic testOverlap();
    logic [7:0] v;
    busWrite(2'd0, 8'h00);
    sendByte(8'hA5);
    waitFree(v);
    sendSym(2'b00); sendSym(2'b00);
    busRead(2'd3, v);
    check("R12 first task data", v, 8'hA5);
    busWrite(2'd0, 8'h00);
    sendSym(2'b11); sendSym(2'b11);
    waitFree(v);
    busRead(2'd3, v);
    check("R12 early symbols used", v, 8'h0F);
  endtask

  task automatic testOverflow();
    logic [7:0] v;
    busRead(2'd1, v);
    check("R10 no overflow yet", v[3], 0);
    for (int b = 0; b < 16; b++) sendByte(8'h40 + 8'(b));
    sendSym(2'b11);
    busRead(2'd1, v);
    check("R10 overflow sticky set", v[3], 1);
    for (int t = 0; t < 2; t++) begin
      busWrite(2'd0, 8'h03);
      waitFree(v);
      for (int k = 0; k < 8; k++) begin
        busRead(2'd3, v);
        check("R10 R7 stored symbols intact", v, 8'h40 + 8'(t*8 + k));
      end
    end
    busRead(2'd1, v);
    check("R10 overflow still set", v[3], 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    testReset();
    testBasic();
    testWait();
    testBusy();
    testPtrReset();
    testOverlap();
    testOverflow();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule